// File: doc/BRIEF.md
# Oversampled Receive Bit Recovery

This block sits behind a demodulator's slicer. The slicer produces hard symbol decisions at four times the baud rate. A clock recovery loop separately marks the moment each bit should be taken. The block keeps a short history of the accepted decisions. On every bit strobe it settles on one received symbol by majority vote over the newest three decisions, so a single glitched decision cannot flip a bit.

The voted symbol then passes through an optional self-synchronizing descrambler with polynomial x^17 + x^12 + 1, which is used only by the high-rate link. In the plain modes the symbol passes through unchanged. Last, an NRZI decoder compares the symbol with the one before it and emits a data bit, marked by a single-cycle valid pulse. The rate selection is taken only on cycles without a strobe, so changing it never splits one bit between two settings. Frame delimiting, bit destuffing and the clock recovery loop itself belong to neighbouring blocks.

Top module: `obr_bit_recovery`

## Requirements
- R1: While `rst_n` is low and after it is released, `data_valid` and `data_bit` are 0. The decision history, the previous-symbol store and the descrambler state are all zero, and the latched rate selection is plain (0).
- R2: A decision on `raw_sym` enters the history only in a cycle with `raw_valid` = 1. With `raw_valid` = 0, `raw_sym` has no effect.
- R3: In a strobe cycle the voted symbol is 1 when at least two of the three most recently accepted decisions are 1, and 0 otherwise. A decision accepted in the strobe cycle itself is not part of that vote.
- R4: With the latched rate selection at 1 (scrambled), the recovered symbol is v XOR s[16] XOR s[11]. Here v is the voted symbol and s is the 17-bit descrambler state, with s[0] holding the newest entry.
- R5: In each scrambled-mode strobe, the voted (received) symbol, not the descrambled one, is shifted into s[0], and every other bit moves up one place.
- R6: With the latched rate selection at 0 (plain), the recovered symbol equals the voted symbol and the descrambler state does not change.
- R7: `data_bit` is 1 when the recovered symbol equals the previously recovered symbol, and 0 when they differ. The previous symbol is 0 after reset.
- R8: `data_valid` is high for exactly one cycle, in the cycle after each strobe edge. `data_bit` changes only together with such a pulse and holds otherwise.
- R9: `rate_sel` is captured only on cycles without a strobe. A strobe uses the value captured on the last cycle without a strobe, even if `rate_sel` changes in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_sym | input | 1 | Hard symbol decision from the slicer |
| raw_valid | input | 1 | Qualifies `raw_sym` for this cycle |
| sample_strobe | input | 1 | Bit-sampling instant from clock recovery |
| rate_sel | input | 1 | 1 = scrambled high-rate link, 0 = plain |
| data_bit | output | 1 | Decoded data bit |
| data_valid | output | 1 | One-cycle pulse marking a new `data_bit` |

## Verification
On every cycle, the assertions check the shifting of the history on accepted decisions and its hold otherwise. They also check that the received symbol, not the output, is shifted into the descrambler. Further cycle-level checks cover the frozen descrambler and pass-through in plain mode, the hold of the latched rate selection across strobes, and the one-pulse-per-strobe timing of `data_valid`. Some results depend on a whole sequence of symbols: the voted value for each window pattern, the NRZI bit values, and the descrambled stream after the state has filled. So do the resumption of scrambled decoding from a frozen state, and the decode of a strobe whose `rate_sel` changed in the same cycle. Only the bench's scenarios show these, using an independent model of the chain.

// File: rtl/obr_pkg.sv
package obr_pkg;

  typedef enum logic {
    RATE_PLAIN     = 1'b0,
    RATE_SCRAMBLED = 1'b1
  } rate_e;

  // multiplicative descrambler output for one received bit
  function automatic logic descr_bit(input logic din, input logic tap_a, input logic tap_b);
    return din ^ tap_a ^ tap_b;
  endfunction

  // NRZI: no transition decodes to 1, a transition to 0
  function automatic logic nrzi_decode(input logic cur, input logic prev);
    return ~(cur ^ prev);
  endfunction

  // strict majority over a window of WIN decisions
  function automatic logic majority_of(input int ones, input int win);
    return (ones * 2) > win;
  endfunction

endpackage

// File: rtl/obr_vote.sv
module obr_vote #(
  parameter int VOTE_WIN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raw_valid,
  input  logic                raw_sym,
  output logic [VOTE_WIN-1:0] hist,
  output logic                voted
);
  import obr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (raw_valid) begin
      hist <= {hist[VOTE_WIN-2:0], raw_sym};
    end
  end

  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < VOTE_WIN; i++) begin
      ones = ones + int'(hist[i]);
    end
    voted = majority_of(ones, VOTE_WIN);
  end

endmodule

// File: rtl/obr_descrambler.sv
module obr_descrambler #(
  parameter int LEN    = 17,
  parameter int TAP_HI = 16,
  parameter int TAP_LO = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           scramble_en,
  input  logic           din,
  output logic           dout,
  output logic [LEN-1:0] state
);
  import obr_pkg::*;

  always_comb begin
    if (scramble_en) begin
      dout = descr_bit(din, state[TAP_HI], state[TAP_LO]);
    end else begin
      dout = din;
    end
  end

  // self-synchronizing: the received bit feeds the register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
    end else if (step && scramble_en) begin
      state <= {state[LEN-2:0], din};
    end
  end

endmodule

// File: rtl/obr_nrzi.sv
module obr_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic sym,
  output logic prev_sym,
  output logic bit_out,
  output logic valid_out
);
  import obr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sym  <= 1'b0;
      bit_out   <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= step;
      if (step) begin
        bit_out  <= nrzi_decode(sym, prev_sym);
        prev_sym <= sym;
      end
    end
  end

endmodule

// File: rtl/obr_bit_recovery.sv
module obr_bit_recovery #(
  parameter int VOTE_WIN   = 3,
  parameter int SCR_LEN    = 17,
  parameter int SCR_TAP_HI = 16,
  parameter int SCR_TAP_LO = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_sym,
  input  logic raw_valid,
  input  logic sample_strobe,
  input  logic rate_sel,
  output logic data_bit,
  output logic data_valid
);
  import obr_pkg::*;

  rate_e               mode_q;
  logic [VOTE_WIN-1:0] raw_hist;
  logic                vote_sym;
  logic                descr_sym;
  logic [SCR_LEN-1:0]  scr_state;
  logic                prev_sym;
  logic                scr_en;

  // rate selection is taken only between strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RATE_PLAIN;
    end else if (!sample_strobe) begin
      mode_q <= rate_e'(rate_sel);
    end
  end

  assign scr_en = (mode_q == RATE_SCRAMBLED);

  obr_vote #(.VOTE_WIN(VOTE_WIN)) vote_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_valid (raw_valid),
    .raw_sym   (raw_sym),
    .hist      (raw_hist),
    .voted     (vote_sym)
  );

  obr_descrambler #(
    .LEN    (SCR_LEN),
    .TAP_HI (SCR_TAP_HI),
    .TAP_LO (SCR_TAP_LO)
  ) descr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (sample_strobe),
    .scramble_en (scr_en),
    .din         (vote_sym),
    .dout        (descr_sym),
    .state       (scr_state)
  );

  obr_nrzi nrzi_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sample_strobe),
    .sym       (descr_sym),
    .prev_sym  (prev_sym),
    .bit_out   (data_bit),
    .valid_out (data_valid)
  );

endmodule

// File: rtl/obr_bit_recovery_chk.sv
module obr_bit_recovery_chk #(
  parameter int VOTE_WIN = 3,
  parameter int SCR_LEN  = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                raw_sym,
  input logic                raw_valid,
  input logic                sample_strobe,
  input logic                scr_en,
  input logic [VOTE_WIN-1:0] raw_hist,
  input logic                vote_sym,
  input logic                descr_sym,
  input logic [SCR_LEN-1:0]  scr_state,
  input logic                prev_sym,
  input logic                data_bit,
  input logic                data_valid
);

  // R2
  hist_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |=> raw_hist[0] == $past(raw_sym));

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> $stable(raw_hist));

  // R5
  scr_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && scr_en) |=> scr_state[0] == $past(vote_sym));

  // R6
  scr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !scr_en) |=> $stable(scr_state));

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_en |-> descr_sym == vote_sym);

  // R7
  prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> prev_sym == $past(descr_sym));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> data_valid);

  // R8
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> !data_valid && $stable(data_bit));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> $stable(scr_en));

endmodule

bind obr_bit_recovery obr_bit_recovery_chk #(
  .VOTE_WIN (VOTE_WIN),
  .SCR_LEN  (SCR_LEN)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .raw_sym       (raw_sym),
  .raw_valid     (raw_valid),
  .sample_strobe (sample_strobe),
  .scr_en        (scr_en),
  .raw_hist      (raw_hist),
  .vote_sym      (vote_sym),
  .descr_sym     (descr_sym),
  .scr_state     (scr_state),
  .prev_sym      (prev_sym),
  .data_bit      (data_bit),
  .data_valid    (data_valid)
);

// File: tb/obr_bit_recovery_tb.sv
module obr_bit_recovery_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_sym = 1'b0;
  logic raw_valid = 1'b0;
  logic sample_strobe = 1'b0;
  logic rate_sel = 1'b0;
  logic data_bit;
  logic data_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // independent model state
  bit m_h0, m_h1, m_h2;
  bit m_prev;
  bit [16:0] m_s;
  bit m_mode;
  bit m_exp_bit;
  bit [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  obr_bit_recovery dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .raw_sym       (raw_sym),
    .raw_valid     (raw_valid),
    .sample_strobe (sample_strobe),
    .rate_sel      (rate_sel),
    .data_bit      (data_bit),
    .data_valid    (data_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[7];
  endfunction

  // one clock: drive at negedge, model the edge, return at next negedge
  task automatic tick(input bit rv, input bit rb, input bit st, input string req);
    int ones;
    bit v, sym;
    raw_valid = rv;
    raw_sym = rb;
    sample_strobe = st;
    @(posedge clk);
    if (st) begin
      ones = int'(m_h0) + int'(m_h1) + int'(m_h2);
      v = (ones >= 2);
      sym = m_mode ? (v ^ m_s[16] ^ m_s[11]) : v;
      if (m_mode) m_s = {m_s[15:0], v};
      m_exp_bit = (sym == m_prev);
      m_prev = sym;
    end
    if (rv) begin
      m_h2 = m_h1;
      m_h1 = m_h0;
      m_h0 = rb;
    end
    if (!st) m_mode = rate_sel;
    @(negedge clk);
    raw_valid = 1'b0;
    sample_strobe = 1'b0;
    if (st) begin
      check(data_valid == 1'b1, req, int'(data_valid), 1);
      check(data_bit == m_exp_bit, req, int'(data_bit), int'(m_exp_bit));
    end
  endtask

  task automatic push3(input bit [2:0] p, input string req);
    tick(1'b1, p[2], 1'b0, req);
    tick(1'b1, p[1], 1'b0, req);
    tick(1'b1, p[0], 1'b0, req);
  endtask

  task automatic t_reset();
    check(data_valid == 1'b0, "R1", int'(data_valid), 0);
    check(data_bit == 1'b0, "R1", int'(data_bit), 0);
    // cleared history, state and previous symbol: first bit decodes to 1
    rate_sel = 1'b1;
    tick(1'b0, 1'b0, 1'b0, "R1");
    tick(1'b0, 1'b0, 1'b1, "R1");
    check(data_bit == 1'b1, "R1", int'(data_bit), 1);
    rate_sel = 1'b0;
    tick(1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_vote();
    bit [2:0] pats [8] = '{3'b110, 3'b100, 3'b101, 3'b001, 3'b111, 3'b000, 3'b011, 3'b010};
    for (int i = 0; i < 8; i++) begin
      push3(pats[i], "R3");
      tick(1'b0, 1'b0, 1'b1, "R3");
    end
    // a decision accepted in the strobe cycle is not voted
    push3(3'b000, "R3");
    tick(1'b1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_nrzi();
    bit [4:0] syms = 5'b11001;
    for (int i = 4; i >= 0; i--) begin
      push3({3{syms[i]}}, "R7");
      tick(1'b0, 1'b0, 1'b1, "R7");
    end
  endtask

  task automatic t_ignore();
    push3(3'b111, "R2");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, "R2");
    tick(1'b0, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_descr();
    rate_sel = 1'b1;
    tick(1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 60; i++) begin
      push3({3{next_rand()}}, (i < 30) ? "R4" : "R5");
      tick(1'b0, 1'b0, 1'b1, (i < 30) ? "R4" : "R5");
    end
  endtask

  task automatic t_bypass();
    rate_sel = 1'b0;
    tick(1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 10; i++) begin
      push3({3{next_rand()}}, "R6");
      tick(1'b0, 1'b0, 1'b1, "R6");
    end
    rate_sel = 1'b1;
    tick(1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 20; i++) begin
      push3({3{next_rand()}}, "R6");
      tick(1'b0, 1'b0, 1'b1, "R6");
    end
  endtask

  task automatic t_valid();
    bit held;
    push3(3'b101, "R8");
    tick(1'b0, 1'b0, 1'b1, "R8");
    held = data_bit;
    tick(1'b1, ~held, 1'b0, "R8");
    check(data_valid == 1'b0, "R8", int'(data_valid), 0);
    check(data_bit == held, "R8", int'(data_bit), int'(held));
    tick(1'b0, 1'b0, 1'b1, "R8");
    tick(1'b0, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_mode();
    for (int k = 0; k < 6; k++) begin
      rate_sel = k[0];
      tick(1'b0, 1'b0, 1'b0, "R9");
      push3({3{next_rand()}}, "R9");
      // flip the selection in the strobe cycle; old value must apply
      rate_sel = ~k[0];
      tick(1'b0, 1'b0, 1'b1, "R9");
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    m_h0 = 0; m_h1 = 0; m_h2 = 0; m_prev = 0; m_s = '0; m_mode = 0;
    t_reset();
    t_vote();
    t_nrzi();
    t_ignore();
    t_descr();
    t_bypass();
    t_valid();
    t_mode();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule